// File: doc/BRIEF.md
# Security-Validating Branch Target Buffer

This block is a set-associative branch target buffer that holds only control-flow transfers confirmed by an external secure record. Each entry is found by branch PC and holds a predicted target plus a few allowed path records. A path record is a branch-history value, the PC of the previous branch and a path length. At fetch the buffer supplies a predicted target. At resolution it re-reads the entry for the resolved branch and sorts the outcome into one of six classes.

No entry is created, retargeted or given a new path record until the external record confirms the whole transfer tuple. That tuple is the branch PC, the computed next PC, the history, the previous branch PC and the size. The request goes out on a valid/ready port. The answer comes back as a single-cycle pass/fail response. While a request is outstanding the block holds `stall` high and ignores new resolutions. If validation fails, `alarm` pulses and the buffer is left untouched. Path records are compared only when the resolved branch is indirect. A branch resolving not-taken against an existing entry deletes that entry and squashes the fetched target.

Top module: `sec_btb`

## Requirements
- R1: With no resolution in flight, `pred_hit` is 1 in the same cycle when `fetch_pc` matches a valid entry, and `pred_target` then carries that entry's target. Otherwise `pred_hit` is 0. A PC never matches more than one way.
- R2: After reset every entry is invalid and the LRU order is reset. `stall`, `alarm`, `squash`, `cls_valid` and `val_req_valid` are 0.
- R3: A taken resolution whose PC is present and whose target equals the stored target is class 1 (hit). It raises no request. If `res_indirect` is 1, it is a hit only when history, previous PC and size all equal one valid path record.
- R4: A taken indirect resolution with a matching target but no matching path record is class 2. A request is issued, and a pass appends the tuple as a path record.
- R5: A taken resolution on a present entry whose target differs is class 3. A request is issued, and a pass writes the new target and appends the path record.
- R6: A not-taken resolution on a present entry is class 4. `squash` pulses with `cls_valid`, and the entry is deleted.
- R7: A taken resolution with no entry is class 5. A request is issued, and a pass inserts an entry whose only path record is the tuple.
- R8: A not-taken resolution with no entry is class 0. Nothing changes and no request is issued.
- R9: `cls_valid` and `cls_code` appear one cycle after `res_valid`. `val_req_valid` rises in the same cycle as `cls_valid` and stays high with a stable tuple until `val_req_ready`. `stall` is high from that cycle until the cycle after the response. A `res_valid` seen while `stall` is high is ignored.
- R10: A failing response pulses `alarm` for exactly one cycle, the cycle after the response, and leaves the buffer contents unchanged.
- R11: A validated insert uses the lowest-numbered invalid way of the set. If every way is valid, it replaces the way least recently touched, where hits and validated commits count as touches.
- R12: Each entry keeps two path records. A validated append overwrites them in round-robin order, starting with the second record after an insert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 16 | PC being fetched |
| pred_hit | output | 1 | Valid entry found for fetch_pc |
| pred_target | output | 16 | Predicted target |
| res_valid | input | 1 | Resolution strobe |
| res_pc | input | 16 | Resolved branch PC |
| res_taken | input | 1 | Branch was taken |
| res_target | input | 16 | Computed next PC |
| res_indirect | input | 1 | Branch is indirect (path check site) |
| res_hist | input | 8 | Dynamic branch-history value |
| res_prev_pc | input | 16 | PC of the previous branch |
| res_size | input | 4 | Path length |
| cls_valid | output | 1 | Classification strobe |
| cls_code | output | 3 | 0 none,1 hit,2 history miss,3 address mispredict,4 direction delete,5 new taken |
| squash | output | 1 | Fetched target must be discarded |
| stall | output | 1 | Validation outstanding |
| alarm | output | 1 | Security alarm pulse |
| val_req_valid | output | 1 | Validation request valid |
| val_req_ready | input | 1 | Validation request accepted |
| val_req_pc | output | 16 | Tuple: branch PC |
| val_req_target | output | 16 | Tuple: computed next PC |
| val_req_hist | output | 8 | Tuple: history |
| val_req_prev_pc | output | 16 | Tuple: previous branch PC |
| val_req_size | output | 4 | Tuple: size |
| val_rsp_valid | input | 1 | Validation response strobe |
| val_rsp_pass | input | 1 | Response verdict (1 = pass) |

## Verification
Fetch prediction is combinational, so the bench sets `fetch_pc` at the falling edge and samples one nanosecond later. The class, `squash` and the request are due one rising edge after `res_valid`, and the bench samples them at the next falling edge. The request must remain visible at every falling edge until the edge that sees `val_req_ready`. The commit, the `alarm` pulse and the drop of `stall` all land on the edge that sees `val_rsp_valid`. The bench checks them one half-cycle later and checks one cycle after that that `alarm` has fallen. All expected values come from a bench model of the entries, path records and recency stamps that is updated only at those points.

// File: rtl/sbtb_pkg.sv
package sbtb_pkg;
  parameter int PC_W   = 16;
  parameter int HIST_W = 8;
  parameter int SIZE_W = 4;

  typedef logic [PC_W-1:0] pc_t;

  typedef struct packed {
    logic              vld;
    logic [HIST_W-1:0] hist;
    pc_t               prev;
    logic [SIZE_W-1:0] size;
  } rec_t;

  typedef enum logic [1:0] {WR_NONE, WR_DEL, WR_INS, WR_UPD} wr_op_e;

  typedef enum logic [2:0] {
    CL_NONE  = 3'd0,
    CL_HIT   = 3'd1,
    CL_HMISS = 3'd2,
    CL_AMISP = 3'd3,
    CL_DDEL  = 3'd4,
    CL_NEW   = 3'd5
  } cls_e;
endpackage

// File: rtl/sbtb_store.sv
module sbtb_store
  import sbtb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int PATHS = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = PC_W - IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int PTR_W = (PATHS > 1) ? $clog2(PATHS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pc_t                 f_pc,
  output logic                f_hit,
  output pc_t                 f_tgt,
  input  pc_t                 r_pc,
  output logic                r_hit,
  output logic [WAY_W-1:0]    r_way,
  output pc_t                 r_tgt,
  output rec_t [PATHS-1:0]    r_recs,
  output logic [WAYS-1:0]     r_vmask,
  input  wr_op_e              wr_op,
  input  pc_t                 wr_pc,
  input  logic [WAY_W-1:0]    wr_way,
  input  pc_t                 wr_tgt,
  input  rec_t                wr_rec
);
  logic             vld_q [SETS][WAYS];
  logic [PTR_W-1:0] rr_q  [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  pc_t              tgt_q [SETS][WAYS];
  rec_t             rec_q [SETS][WAYS][PATHS];

  logic [IDX_W-1:0] f_set, r_set, w_set;
  logic [TAG_W-1:0] f_tag, r_tag, w_tag;
  logic [WAYS-1:0]  f_hv, r_hv;

  assign f_set = f_pc[IDX_W-1:0];
  assign f_tag = f_pc[PC_W-1:IDX_W];
  assign r_set = r_pc[IDX_W-1:0];
  assign r_tag = r_pc[PC_W-1:IDX_W];
  assign w_set = wr_pc[IDX_W-1:0];
  assign w_tag = wr_pc[PC_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign f_hv[w]    = vld_q[f_set][w] && (tag_q[f_set][w] == f_tag);
    assign r_hv[w]    = vld_q[r_set][w] && (tag_q[r_set][w] == r_tag);
    assign r_vmask[w] = vld_q[r_set][w];
  end

  assign f_hit = |f_hv;
  assign r_hit = |r_hv;

  always_comb begin
    f_tgt = '0;
    r_tgt = '0;
    r_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (f_hv[w]) f_tgt = tgt_q[f_set][w];
      if (r_hv[w]) begin
        r_tgt = tgt_q[r_set][w];
        r_way = WAY_W'(w);
      end
    end
    for (int p = 0; p < PATHS; p++) r_recs[p] = rec_q[r_set][r_way][p];
  end

  // control state: valid bits and round-robin pointers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          rr_q[s][w]  <= '0;
        end
    end else if (wr_op != WR_NONE) begin
      case (wr_op)
        WR_DEL: vld_q[w_set][wr_way] <= 1'b0;
        WR_INS: begin
          vld_q[w_set][wr_way] <= 1'b1;
          rr_q[w_set][wr_way]  <= (PATHS > 1) ? PTR_W'(1) : '0;
        end
        WR_UPD: rr_q[w_set][wr_way] <= (rr_q[w_set][wr_way] == PTR_W'(PATHS-1)) ?
                                       '0 : rr_q[w_set][wr_way] + 1'b1;
        default: ;
      endcase
    end
  end

  // payload: no reset, guarded by the valid bits
  always_ff @(posedge clk) begin
    if (wr_op == WR_INS) begin
      tag_q[w_set][wr_way] <= w_tag;
      tgt_q[w_set][wr_way] <= wr_tgt;
      for (int p = 0; p < PATHS; p++)
        rec_q[w_set][wr_way][p] <= (p == 0) ? wr_rec : '0;
    end else if (wr_op == WR_UPD) begin
      tgt_q[w_set][wr_way] <= wr_tgt;
      rec_q[w_set][wr_way][rr_q[w_set][wr_way]] <= wr_rec;
    end
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(f_hv) && $onehot0(r_hv)); // R1
endmodule

// File: rtl/sbtb_lru.sv
module sbtb_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] t_set,
  input  logic [WAY_W-1:0] t_way,
  input  logic [IDX_W-1:0] q_set,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  oldest_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == t_way)
          age_q[t_set][w] <= '0;
        else if (age_q[t_set][w] < age_q[t_set][t_way])
          age_q[t_set][w] <= age_q[t_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      oldest_v[w] = (age_q[q_set][w] == WAY_W'(WAYS-1));
      if (oldest_v[w]) victim = WAY_W'(w);
    end
  end

  AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_v)); // R11
endmodule

// File: rtl/sbtb_ctrl.sv
module sbtb_ctrl
  import sbtb_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int PATHS = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  pc_t               res_pc,
  input  logic              res_taken,
  input  pc_t               res_target,
  input  logic              res_indirect,
  input  logic [HIST_W-1:0] res_hist,
  input  pc_t               res_prev_pc,
  input  logic [SIZE_W-1:0] res_size,
  input  logic              lk_hit,
  input  logic [WAY_W-1:0]  lk_way,
  input  pc_t               lk_tgt,
  input  rec_t [PATHS-1:0]  lk_recs,
  input  logic [WAYS-1:0]   lk_vmask,
  input  logic [WAY_W-1:0]  lru_way,
  output wr_op_e            wr_op,
  output pc_t               wr_pc,
  output logic [WAY_W-1:0]  wr_way,
  output pc_t               wr_tgt,
  output rec_t              wr_rec,
  output logic              touch,
  output pc_t               touch_pc,
  output logic [WAY_W-1:0]  touch_way,
  output logic              cls_valid,
  output logic [2:0]        cls_code,
  output logic              squash,
  output logic              stall,
  output logic              alarm,
  output logic              val_req_valid,
  input  logic              val_req_ready,
  output pc_t               val_req_pc,
  output pc_t               val_req_target,
  output logic [HIST_W-1:0] val_req_hist,
  output pc_t               val_req_prev_pc,
  output logic [SIZE_W-1:0] val_req_size,
  input  logic              val_rsp_valid,
  input  logic              val_rsp_pass
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

  st_e               st_q, st_d;
  logic              clsv_q, clsv_d, sq_q, sq_d, al_q, al_d;
  cls_e              cls_q, cls_d;
  wr_op_e            pop_q, pop_d;
  logic [WAY_W-1:0]  pway_q, pway_d;
  pc_t               rpc_q, rpc_d, rtg_q, rtg_d, rpv_q, rpv_d;
  logic [HIST_W-1:0] rhs_q, rhs_d;
  logic [SIZE_W-1:0] rsz_q, rsz_d;
  logic              path_hit, vic_found;
  logic [WAY_W-1:0]  vic;

  always_comb begin
    path_hit = 1'b0;
    for (int p = 0; p < PATHS; p++)
      if (lk_recs[p].vld && lk_recs[p].hist == res_hist &&
          lk_recs[p].prev == res_prev_pc && lk_recs[p].size == res_size)
        path_hit = 1'b1;
    vic       = lru_way;
    vic_found = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (!vic_found && !lk_vmask[w]) begin
        vic       = WAY_W'(w);
        vic_found = 1'b1;
      end
  end

  always_comb begin
    st_d   = st_q;
    clsv_d = 1'b0;
    cls_d  = cls_q;
    sq_d   = 1'b0;
    al_d   = 1'b0;
    pop_d  = pop_q;
    pway_d = pway_q;
    rpc_d  = rpc_q;
    rtg_d  = rtg_q;
    rpv_d  = rpv_q;
    rhs_d  = rhs_q;
    rsz_d  = rsz_q;
    wr_op     = WR_NONE;
    wr_pc     = res_pc;
    wr_way    = lk_way;
    wr_tgt    = rtg_q;
    wr_rec    = '{vld: 1'b1, hist: rhs_q, prev: rpv_q, size: rsz_q};
    touch     = 1'b0;
    touch_pc  = res_pc;
    touch_way = lk_way;
    case (st_q)
      S_IDLE: if (res_valid) begin
        clsv_d = 1'b1;
        rpc_d  = res_pc;
        rtg_d  = res_target;
        rpv_d  = res_prev_pc;
        rhs_d  = res_hist;
        rsz_d  = res_size;
        if (lk_hit) begin
          pway_d = lk_way;
          pop_d  = WR_UPD;
          if (!res_taken) begin
            cls_d = CL_DDEL;
            sq_d  = 1'b1;
            wr_op = WR_DEL;
          end else if (res_target != lk_tgt) begin
            cls_d = CL_AMISP;
            st_d  = S_REQ;
          end else if (res_indirect && !path_hit) begin
            cls_d = CL_HMISS;
            st_d  = S_REQ;
          end else begin
            cls_d = CL_HIT;
            touch = 1'b1;
          end
        end else if (res_taken) begin
          cls_d  = CL_NEW;
          st_d   = S_REQ;
          pop_d  = WR_INS;
          pway_d = vic;
        end else begin
          cls_d = CL_NONE;
        end
      end
      S_REQ: if (val_req_ready) st_d = S_WAIT;
      S_WAIT: if (val_rsp_valid) begin
        st_d = S_IDLE;
        if (val_rsp_pass) begin
          wr_op     = pop_q;
          wr_pc     = rpc_q;
          wr_way    = pway_q;
          touch     = 1'b1;
          touch_pc  = rpc_q;
          touch_way = pway_q;
        end else begin
          al_d = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      clsv_q <= 1'b0;
      cls_q  <= CL_NONE;
      sq_q   <= 1'b0;
      al_q   <= 1'b0;
      pop_q  <= WR_NONE;
      pway_q <= '0;
    end else begin
      st_q   <= st_d;
      clsv_q <= clsv_d;
      cls_q  <= cls_d;
      sq_q   <= sq_d;
      al_q   <= al_d;
      pop_q  <= pop_d;
      pway_q <= pway_d;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == S_IDLE && res_valid) begin
      rpc_q <= rpc_d;
      rtg_q <= rtg_d;
      rpv_q <= rpv_d;
      rhs_q <= rhs_d;
      rsz_q <= rsz_d;
    end
  end

  assign cls_valid       = clsv_q;
  assign cls_code        = cls_q;
  assign squash          = sq_q;
  assign alarm           = al_q;
  assign stall           = (st_q != S_IDLE);
  assign val_req_valid   = (st_q == S_REQ);
  assign val_req_pc      = rpc_q;
  assign val_req_target  = rtg_q;
  assign val_req_hist    = rhs_q;
  assign val_req_prev_pc = rpv_q;
  assign val_req_size    = rsz_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    val_req_valid && !val_req_ready |=> val_req_valid && $stable(val_req_pc) &&
      $stable(val_req_target) && $stable(val_req_hist)); // R9
  AST_ALARM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> !alarm); // R10
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !val_req_valid && val_rsp_valid && !val_rsp_pass |-> wr_op == WR_NONE); // R10
  AST_STALL_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(val_req_valid) |-> stall && cls_valid); // R9
endmodule

// File: rtl/sec_btb.sv
module sec_btb
  import sbtb_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int PATHS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              pred_hit,
  output logic [PC_W-1:0]   pred_target,
  input  logic              res_valid,
  input  logic [PC_W-1:0]   res_pc,
  input  logic              res_taken,
  input  logic [PC_W-1:0]   res_target,
  input  logic              res_indirect,
  input  logic [HIST_W-1:0] res_hist,
  input  logic [PC_W-1:0]   res_prev_pc,
  input  logic [SIZE_W-1:0] res_size,
  output logic              cls_valid,
  output logic [2:0]        cls_code,
  output logic              squash,
  output logic              stall,
  output logic              alarm,
  output logic              val_req_valid,
  input  logic              val_req_ready,
  output logic [PC_W-1:0]   val_req_pc,
  output logic [PC_W-1:0]   val_req_target,
  output logic [HIST_W-1:0] val_req_hist,
  output logic [PC_W-1:0]   val_req_prev_pc,
  output logic [SIZE_W-1:0] val_req_size,
  input  logic              val_rsp_valid,
  input  logic              val_rsp_pass
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic             lk_hit;
  logic [WAY_W-1:0] lk_way, lru_way, wr_way, touch_way;
  pc_t              lk_tgt, wr_pc, wr_tgt, touch_pc;
  rec_t [PATHS-1:0] lk_recs;
  logic [WAYS-1:0]  lk_vmask;
  wr_op_e           wr_op;
  rec_t             wr_rec;
  logic             touch;

  sbtb_store #(.SETS(SETS), .WAYS(WAYS), .PATHS(PATHS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .f_pc(fetch_pc), .f_hit(pred_hit), .f_tgt(pred_target),
    .r_pc(res_pc), .r_hit(lk_hit), .r_way(lk_way), .r_tgt(lk_tgt),
    .r_recs(lk_recs), .r_vmask(lk_vmask),
    .wr_op(wr_op), .wr_pc(wr_pc), .wr_way(wr_way), .wr_tgt(wr_tgt), .wr_rec(wr_rec)
  );

  sbtb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch(touch), .t_set(touch_pc[IDX_W-1:0]), .t_way(touch_way),
    .q_set(res_pc[IDX_W-1:0]), .victim(lru_way)
  );

  sbtb_ctrl #(.WAYS(WAYS), .PATHS(PATHS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_indirect(res_indirect), .res_hist(res_hist),
    .res_prev_pc(res_prev_pc), .res_size(res_size),
    .lk_hit(lk_hit), .lk_way(lk_way), .lk_tgt(lk_tgt), .lk_recs(lk_recs),
    .lk_vmask(lk_vmask), .lru_way(lru_way),
    .wr_op(wr_op), .wr_pc(wr_pc), .wr_way(wr_way), .wr_tgt(wr_tgt), .wr_rec(wr_rec),
    .touch(touch), .touch_pc(touch_pc), .touch_way(touch_way),
    .cls_valid(cls_valid), .cls_code(cls_code), .squash(squash),
    .stall(stall), .alarm(alarm),
    .val_req_valid(val_req_valid), .val_req_ready(val_req_ready),
    .val_req_pc(val_req_pc), .val_req_target(val_req_target),
    .val_req_hist(val_req_hist), .val_req_prev_pc(val_req_prev_pc),
    .val_req_size(val_req_size),
    .val_rsp_valid(val_rsp_valid), .val_rsp_pass(val_rsp_pass)
  );
endmodule

// File: tb/tb_sec_btb.sv
module tb_sec_btb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] fetch_pc, res_pc, res_target, res_prev_pc;
  logic        pred_hit, res_valid, res_taken, res_indirect;
  logic [15:0] pred_target;
  logic [7:0]  res_hist;
  logic [3:0]  res_size;
  logic        cls_valid, squash, stall, alarm, val_req_valid, val_req_ready;
  logic [2:0]  cls_code;
  logic [15:0] val_req_pc, val_req_target, val_req_prev_pc;
  logic [7:0]  val_req_hist;
  logic [3:0]  val_req_size;
  logic        val_rsp_valid, val_rsp_pass;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int last_cls;

  always #10 clk = ~clk;

  sec_btb dut (.*);

  // bench model
  bit          m_vld [16][4];
  logic [15:0] m_pc  [16][4];
  logic [15:0] m_tgt [16][4];
  bit          m_rv  [16][4][2];
  logic [7:0]  m_rh  [16][4][2];
  logic [15:0] m_rp  [16][4][2];
  logic [3:0]  m_rs  [16][4][2];
  int          m_rr  [16][4];
  int          m_st  [16][4];
  int          tnow = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int mfind(input logic [15:0] pc);
    for (int w = 0; w < 4; w++)
      if (m_vld[pc[3:0]][w] && m_pc[pc[3:0]][w] == pc) return w;
    return -1;
  endfunction

  function automatic int mvictim(input int s);
    int best = 0;
    for (int w = 0; w < 4; w++) if (!m_vld[s][w]) return w;
    for (int w = 1; w < 4; w++) if (m_st[s][w] < m_st[s][best]) best = w;
    return best;
  endfunction

  function automatic bit mpath(input int s, input int w, input logic [7:0] h,
                               input logic [15:0] p, input logic [3:0] z);
    for (int k = 0; k < 2; k++)
      if (m_rv[s][w][k] && m_rh[s][w][k] == h && m_rp[s][w][k] == p && m_rs[s][w][k] == z)
        return 1;
    return 0;
  endfunction

  function automatic string creq(input int c);
    case (c)
      0: return "R8";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic fetch_chk(input logic [15:0] pc, input string req);
    int w;
    fetch_pc = pc;
    #1;
    w = mfind(pc);
    check(pred_hit == (w >= 0), req, "pred_hit", pred_hit, w >= 0);
    if (w >= 0)
      check(pred_target == m_tgt[pc[3:0]][w], req, "pred_target",
            pred_target, m_tgt[pc[3:0]][w]);
  endtask

  task automatic run_res(input logic [15:0] pc, input bit tk, input logic [15:0] tg,
                         input bit ind, input logic [7:0] h, input logic [15:0] pp,
                         input logic [3:0] sz, input bit pass, input int dr,
                         input int dv, input bit poke);
    int s = pc[3:0];
    int w = mfind(pc);
    int exp, vw;
    bit needv;
    if (w >= 0) begin
      if (!tk) exp = 4;
      else if (tg != m_tgt[s][w]) exp = 3;
      else if (ind && !mpath(s, w, h, pp, sz)) exp = 2;
      else exp = 1;
    end else exp = tk ? 5 : 0;
    needv = (exp == 2 || exp == 3 || exp == 5);
    vw = (exp == 5) ? mvictim(s) : w;

    res_pc = pc; res_taken = tk; res_target = tg; res_indirect = ind;
    res_hist = h; res_prev_pc = pp; res_size = sz; res_valid = 1'b1;
    tick;
    res_valid = 1'b0;
    last_cls = int'(cls_code);
    check(cls_valid == 1'b1, "R9", "cls_valid", cls_valid, 1);
    check(int'(cls_code) == exp, creq(exp), "cls_code", cls_code, exp);
    check(squash == (exp == 4), "R6", "squash", squash, exp == 4);
    if (exp == 4) m_vld[s][w] = 0;
    if (exp == 1) m_st[s][w] = ++tnow;

    if (needv) begin
      check(val_req_valid && stall, "R9", "request+stall", {val_req_valid, stall}, 3);
      check(val_req_pc == pc && val_req_target == tg, creq(exp), "tuple pc/target",
            val_req_target, tg);
      check(val_req_hist == h && val_req_prev_pc == pp && val_req_size == sz,
            creq(exp), "tuple path", val_req_hist, h);
      for (int i = 0; i < dr; i++) begin
        tick;
        check(val_req_valid && val_req_pc == pc, "R9", "request held", val_req_valid, 1);
      end
      val_req_ready = 1'b1;
      tick;
      val_req_ready = 1'b0;
      check(!val_req_valid && stall, "R9", "waiting", {val_req_valid, stall}, 1);
      if (poke) begin
        res_pc = 16'h0FF0; res_taken = 1'b1; res_valid = 1'b1;
        tick;
        res_valid = 1'b0;
        check(cls_valid == 1'b0, "R9", "ignored cls_valid", cls_valid, 0);
      end
      for (int i = 0; i < dv; i++) tick;
      val_rsp_valid = 1'b1; val_rsp_pass = pass;
      tick;
      val_rsp_valid = 1'b0;
      check(alarm == !pass, pass ? creq(exp) : "R10", "alarm", alarm, !pass);
      check(stall == 1'b0, "R9", "stall released", stall, 0);
      tick;
      check(alarm == 1'b0, "R10", "alarm pulse end", alarm, 0);
      if (pass) begin
        if (exp == 5) begin
          m_vld[s][vw] = 1; m_pc[s][vw] = pc; m_rr[s][vw] = 1;
          m_rv[s][vw][1] = 0;
          m_rv[s][vw][0] = 1; m_rh[s][vw][0] = h; m_rp[s][vw][0] = pp; m_rs[s][vw][0] = sz;
        end else begin
          m_rv[s][vw][m_rr[s][vw]] = 1; m_rh[s][vw][m_rr[s][vw]] = h;
          m_rp[s][vw][m_rr[s][vw]] = pp; m_rs[s][vw][m_rr[s][vw]] = sz;
          m_rr[s][vw] ^= 1;
        end
        m_tgt[s][vw] = tg;
        m_st[s][vw] = ++tnow;
      end
      if (poke) fetch_chk(16'h0FF0, "R9");
    end else begin
      check(!val_req_valid && !stall, "R9", "no request", {val_req_valid, stall}, 0);
    end
    fetch_chk(pc, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; fetch_pc = '0; res_valid = 0; res_pc = '0; res_taken = 0;
    res_target = '0; res_indirect = 0; res_hist = '0; res_prev_pc = '0;
    res_size = '0; val_req_ready = 0; val_rsp_valid = 0; val_rsp_pass = 0;
    for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({stall, alarm, squash, cls_valid, val_req_valid} == 5'b0, "R2", "outputs idle",
          {stall, alarm, squash, cls_valid, val_req_valid}, 0);
    fetch_chk(16'h0105, "R2");
    fetch_chk(16'h0000, "R2");

    // directed: set 5
    run_res(16'h0105, 0, 16'h2000, 1, 8'h11, 16'h0040, 4'd3, 1, 0, 0, 0);
    run_res(16'h0105, 1, 16'h2000, 1, 8'h11, 16'h0040, 4'd3, 0, 1, 1, 0);
    check(pred_hit == 1'b0, "R10", "no insert on fail", pred_hit, 0);
    run_res(16'h0105, 1, 16'h2000, 1, 8'h11, 16'h0040, 4'd3, 1, 0, 2, 1);
    run_res(16'h0105, 1, 16'h2000, 1, 8'h11, 16'h0040, 4'd3, 1, 0, 0, 0);
    run_res(16'h0105, 1, 16'h2000, 1, 8'h22, 16'h0040, 4'd3, 1, 2, 0, 0);
    run_res(16'h0105, 1, 16'h2000, 1, 8'h33, 16'h0040, 4'd3, 1, 0, 1, 0);
    run_res(16'h0105, 1, 16'h2000, 1, 8'h11, 16'h0040, 4'd3, 0, 0, 0, 0);
    check(last_cls == 2, "R12", "oldest record replaced", last_cls, 2);
    run_res(16'h0105, 1, 16'h2000, 1, 8'h22, 16'h0040, 4'd3, 1, 0, 0, 0);
    check(last_cls == 1, "R12", "newer record kept", last_cls, 1);
    run_res(16'h0105, 1, 16'h2000, 0, 8'h77, 16'h0041, 4'd1, 1, 0, 0, 0);
    check(last_cls == 1, "R3", "direct branch skips path check", last_cls, 1);
    run_res(16'h0105, 1, 16'h2100, 0, 8'h44, 16'h0040, 4'd2, 1, 1, 0, 0);
    check(pred_target == 16'h2100, "R5", "retargeted", pred_target, 16'h2100);
    run_res(16'h0105, 0, 16'h2100, 0, 8'h44, 16'h0040, 4'd2, 1, 0, 0, 0);
    check(pred_hit == 1'b0, "R6", "entry deleted", pred_hit, 0);
    for (int i = 1; i <= 4; i++)
      run_res(16'h0005 | (16'(i) << 8), 1, 16'h3000, 0, 8'h01, 16'h0, 4'd1, 1, 0, 0, 0);
    run_res(16'h0105, 1, 16'h3000, 0, 8'h01, 16'h0, 4'd1, 1, 0, 0, 0);
    run_res(16'h0505, 1, 16'h3000, 0, 8'h01, 16'h0, 4'd1, 1, 0, 0, 0);
    fetch_chk(16'h0205, "R11");
    check(pred_hit == 1'b0, "R11", "LRU way evicted", pred_hit, 0);
    fetch_chk(16'h0105, "R11");
    check(pred_hit == 1'b1, "R11", "recent way kept", pred_hit, 1);

    // constrained random: sets 0..2, six tags per set
    for (int i = 0; i < 400; i++) begin
      logic [15:0] pc, tg, pp;
      logic [7:0]  h;
      logic [3:0]  sz;
      pc = 16'((($urandom % 6) << 4) | ($urandom % 3));
      tg = 16'h4000 + 16'(($urandom % 3) << 4);
      pp = 16'h0080 + 16'($urandom % 2);
      h  = 8'h10 + 8'($urandom % 3);
      sz = 4'($urandom % 2);
      run_res(pc, ($urandom % 4) != 0, tg, $urandom % 2, h, pp, sz,
              ($urandom % 5) != 0, $urandom % 3, $urandom % 3, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule